// File: doc/BRIEF.md
# Four-Slot Transmit Descriptor Engine

This block moves outgoing frames from system memory to a MAC-side byte interface. Software owns four descriptor slots. Each slot has a 32-bit buffer address word and a 32-bit command/status word. Software first loads the buffer address. It then writes the status word with a byte count and a start threshold. That write hands the slot to the hardware and queues it.

The engine serves the slots in a fixed rotation. It reads the frame one byte at a time through a simple memory read port into an internal FIFO. It starts offering bytes to the MAC once enough data is buffered. When the MAC signals the end of the frame, the engine records the outcome in the slot's status word and raises one of two shared interrupt flags. The engine adds no padding and makes no frame check sequence. The MAC appends the 4 check bytes, so a 60-byte buffer goes on the wire as 64 bytes.

A failed frame leaves the rotation pointer on the same slot, so software can rewrite that slot to retry it. Byte counts are 1 or more.

Top module: `tx_desc_engine`

## Requirements
- R1: After reset, every status word reads 0x0000_2000 (bit13 host-owned set, all else 0), every address word and the interrupt word read 0, and `tx_active` and `mem_rd_en` are low.
- R2: Register words are selected by `reg_addr`: 0..3 are the status words of slots 0..3, 4..7 are the buffer address words of slots 0..3, and 8 is the interrupt word. An address word reads back the 32 bits written to it.
- R3: A write to a status word stores the byte count from bits [12:0] and the threshold from bits [21:16]. It clears bit13 (host-owned), bit14 (underrun), bit15 (sent OK) and bits [31:29] (MAC errors), and it queues the slot.
- R4: A frame delivers exactly `count` bytes, read from buffer address, address+1, and onwards, in that order and with no padding. `tx_last` is high with the final byte. `tx_active` drops after the final byte is taken.
- R5: `tx_active` rises only when the buffered byte count reaches threshold×32, the whole frame has been fetched, or the FIFO is full, whichever comes first.
- R6: Bit13 of the slot's status word is set as soon as all of its bytes have been fetched, before the MAC reports completion.
- R7: On `mac_done`, a zero `mac_err` sets bit15 and interrupt bit2 (sent OK). A nonzero `mac_err` is copied to status bits [31:29] ({carrier lost, aborted, late collision}) and sets interrupt bit3 (error).
- R8: Slots are served strictly in the order 0,1,2,3,0. A queued slot that is not at the pointer waits with no memory reads. The pointer advances only after a frame completes with sent OK.
- R9: If the MAC pulls a byte while the FIFO is empty, the frame is abandoned. Status bits 14 and 13 are set, interrupt bit3 is raised, `tx_active` is low on the next cycle, and the pointer stays on that slot.
- R10: Interrupt bits 2 and 3 clear only when a 1 is written to them. Writing 0 leaves them unchanged. `irq_tx_ok` and `irq_tx_err` follow bits 2 and 3.
- R11: The FIFO is never written when full, and no more than `count` memory reads are issued for a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word select (also selects `reg_rdata`) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Contents of the selected register word |
| mem_rd_en | output | 1 | Byte read request |
| mem_addr | output | 32 | Byte address of the request |
| mem_rd_data | input | 8 | Read data, valid one cycle after the request |
| tx_active | output | 1 | A frame is being offered to the MAC |
| tx_data | output | 8 | Byte at the head of the FIFO |
| tx_last | output | 1 | `tx_data` is the final byte of the frame |
| mac_pull | input | 1 | MAC takes `tx_data` this cycle |
| mac_done | input | 1 | MAC finished the frame, including the check bytes |
| mac_err | input | 3 | MAC outcome flags, sampled with `mac_done` |
| irq_tx_ok | output | 1 | Interrupt bit2 |
| irq_tx_err | output | 1 | Interrupt bit3 |

## Verification
The bench targets three corner cases of the start rule.
- A threshold below the frame length: a design that ignored the threshold would start at once and underrun.
- A frame shorter than its threshold: a design that waited only for the threshold would never start.
- A threshold larger than the FIFO: a design that did not start on a full FIFO would deadlock.

The bench forces an underrun by pulling on the very first active cycle. It then retries the same slot, which fails with a timeout if the pointer wrongly advanced. It queues a slot out of turn to catch a design that serves whatever is pending instead of keeping the rotation. A MAC error outcome checks that the pointer holds and that the error flags land in the right bits.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int unsigned LEN_W = 13;
  localparam int unsigned THR_W = 6;
  localparam int unsigned AW    = 32;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FILL,
    ST_SEND,
    ST_WAIT
  } txd_state_e;

  // threshold field counts 32-byte units
  function automatic logic [LEN_W:0] thr_to_bytes(input logic [THR_W-1:0] thr);
    return {{(LEN_W + 1 - THR_W - 5){1'b0}}, thr, 5'b0};
  endfunction

  // status word layout: len[12:0] own[13] unr[14] ok[15] thr[21:16] err[31:29]
  function automatic logic [31:0] pack_status(input logic [LEN_W-1:0] len,
                                              input logic [THR_W-1:0] thr,
                                              input logic own, input logic unr,
                                              input logic ok, input logic [2:0] err);
    return {err, 7'b0, thr, ok, unr, own, len};
  endfunction
endpackage

// File: rtl/txd_byte_fifo.sv
module txd_byte_fifo #(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned W     = 8,
  localparam int unsigned PW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign rd_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (wr_en && !flush) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= wr_ptr + 1'b1;
      if (rd_en) rd_ptr <= rd_ptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush) |-> (!full || rd_en))
    else $error("fifo written while full");

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> !empty)
    else $error("fifo read while empty");
endmodule

// File: rtl/txd_desc_regs.sv
module txd_desc_regs
  import txd_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 4,
  localparam int unsigned SW = $clog2(NUM_SLOTS),
  localparam int unsigned RAW = $clog2(2 * NUM_SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [RAW-1:0]   reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic [SW-1:0]    cur_slot,
  output logic             cur_pending,
  output logic [AW-1:0]    cur_addr,
  output logic [LEN_W-1:0] cur_len,
  output logic [THR_W-1:0] cur_thr,
  input  logic             own_set,
  input  logic             cmp_valid,
  input  logic             cmp_ok,
  input  logic             cmp_underrun,
  input  logic [2:0]       cmp_mac_err,
  output logic             irq_ok,
  output logic             irq_err
);
  logic [AW-1:0]    s_addr [NUM_SLOTS];
  logic [LEN_W-1:0] s_len  [NUM_SLOTS];
  logic [THR_W-1:0] s_thr  [NUM_SLOTS];
  logic [2:0]       s_err  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] s_own, s_unr, s_ok, s_pend;
  logic [SW-1:0]    ptr;

  function automatic logic [SW-1:0] next_slot(input logic [SW-1:0] s);
    return (s == SW'(NUM_SLOTS - 1)) ? '0 : s + 1'b1;
  endfunction

  wire int_hit = reg_wr_en && (reg_addr == RAW'(2 * NUM_SLOTS));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    wire st_hit = reg_wr_en && (reg_addr == RAW'(i));
    wire ad_hit = reg_wr_en && (reg_addr == RAW'(NUM_SLOTS + i));
    wire is_cur = (ptr == SW'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) s_addr[i] <= '0;
      else if (ad_hit) s_addr[i] <= reg_wdata;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        s_len[i]  <= '0;
        s_thr[i]  <= '0;
        s_err[i]  <= '0;
        s_own[i]  <= 1'b1;
        s_unr[i]  <= 1'b0;
        s_ok[i]   <= 1'b0;
        s_pend[i] <= 1'b0;
      end else if (st_hit) begin
        s_len[i]  <= reg_wdata[LEN_W-1:0];
        s_thr[i]  <= reg_wdata[16 +: THR_W];
        s_err[i]  <= '0;
        s_own[i]  <= 1'b0;
        s_unr[i]  <= 1'b0;
        s_ok[i]   <= 1'b0;
        s_pend[i] <= 1'b1;
      end else if (is_cur) begin
        if (own_set) s_own[i] <= 1'b1;
        if (cmp_valid) begin
          s_pend[i] <= 1'b0;
          s_own[i]  <= 1'b1;
          s_ok[i]   <= cmp_ok;
          s_unr[i]  <= cmp_underrun;
          s_err[i]  <= cmp_mac_err;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else if (cmp_valid && cmp_ok) ptr <= next_slot(ptr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_ok  <= 1'b0;
      irq_err <= 1'b0;
    end else begin
      irq_ok  <= (irq_ok  & ~(int_hit & reg_wdata[2])) | (cmp_valid &  cmp_ok);
      irq_err <= (irq_err & ~(int_hit & reg_wdata[3])) | (cmp_valid & ~cmp_ok);
    end
  end

  assign cur_slot    = ptr;
  assign cur_pending = s_pend[ptr];
  assign cur_addr    = s_addr[ptr];
  assign cur_len     = s_len[ptr];
  assign cur_thr     = s_thr[ptr];

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < RAW'(NUM_SLOTS)) begin
      reg_rdata = pack_status(s_len[reg_addr[SW-1:0]], s_thr[reg_addr[SW-1:0]],
                              s_own[reg_addr[SW-1:0]], s_unr[reg_addr[SW-1:0]],
                              s_ok[reg_addr[SW-1:0]], s_err[reg_addr[SW-1:0]]);
    end else if (reg_addr < RAW'(2 * NUM_SLOTS)) begin
      reg_rdata = s_addr[reg_addr[SW-1:0]];
    end else if (reg_addr == RAW'(2 * NUM_SLOTS)) begin
      reg_rdata = {28'b0, irq_err, irq_ok, 2'b0};
    end
  end
endmodule

// File: rtl/txd_xfer_ctrl.sv
module txd_xfer_ctrl
  import txd_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cur_pending,
  input  logic [AW-1:0]    cur_addr,
  input  logic [LEN_W-1:0] cur_len,
  input  logic [THR_W-1:0] cur_thr,
  output logic             mem_rd_en,
  output logic [AW-1:0]    mem_addr,
  input  logic [7:0]       mem_rd_data,
  output logic             tx_active,
  output logic [7:0]       tx_data,
  output logic             tx_last,
  input  logic             mac_pull,
  input  logic             mac_done,
  input  logic [2:0]       mac_err,
  output logic             ev_fetch_done,
  output logic             ev_underrun,
  output logic             ev_complete,
  output logic             cmp_ok,
  output logic [2:0]       cmp_mac_err
);
  txd_state_e       state;
  logic [LEN_W-1:0] req_cnt, got_cnt, sent_cnt;
  logic             inflight;
  logic [CW-1:0]    f_count;
  logic             f_empty, f_full, f_wr, f_rd, f_flush;

  wire fetching    = (state == ST_FILL) || (state == ST_SEND);
  wire room        = ((CW+1)'(f_count) + (CW+1)'(inflight)) < (CW+1)'(FIFO_DEPTH);
  wire [LEN_W-1:0] len_m1 = cur_len - LEN_W'(1);
  wire all_fetched = (got_cnt == cur_len);
  wire start_ok    = ({1'b0, got_cnt} >= thr_to_bytes(cur_thr)) || all_fetched || f_full;
  wire last_pop    = f_rd && (sent_cnt == len_m1);

  assign mem_rd_en     = fetching && (req_cnt < cur_len) && room;
  assign mem_addr      = cur_addr + AW'(req_cnt);
  assign f_wr          = inflight && fetching;
  assign f_rd          = (state == ST_SEND) && mac_pull && !f_empty;
  assign ev_underrun   = (state == ST_SEND) && mac_pull && f_empty;
  assign f_flush       = ev_underrun || (state == ST_IDLE);
  assign ev_fetch_done = f_wr && (got_cnt == len_m1);
  assign ev_complete   = ((state == ST_WAIT) && mac_done) || ev_underrun;
  assign cmp_ok        = (state == ST_WAIT) && (mac_err == 3'b000);
  assign cmp_mac_err   = (state == ST_WAIT) ? mac_err : 3'b000;
  assign tx_active     = (state == ST_SEND);
  assign tx_last       = (state == ST_SEND) && (sent_cnt == len_m1);

  txd_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (f_flush),
    .wr_en   (f_wr),
    .wr_data (mem_rd_data),
    .rd_en   (f_rd),
    .rd_data (tx_data),
    .count   (f_count),
    .empty   (f_empty),
    .full    (f_full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      req_cnt  <= '0;
      got_cnt  <= '0;
      sent_cnt <= '0;
      inflight <= 1'b0;
    end else begin
      inflight <= mem_rd_en;
      if (mem_rd_en) req_cnt  <= req_cnt + 1'b1;
      if (f_wr)      got_cnt  <= got_cnt + 1'b1;
      if (f_rd)      sent_cnt <= sent_cnt + 1'b1;
      case (state)
        ST_IDLE: begin
          req_cnt  <= '0;
          got_cnt  <= '0;
          sent_cnt <= '0;
          if (cur_pending) state <= ST_FILL;
        end
        ST_FILL: if (start_ok) state <= ST_SEND;
        ST_SEND: begin
          if (ev_underrun)   state <= ST_IDLE;
          else if (last_pop) state <= ST_WAIT;
        end
        ST_WAIT: if (mac_done) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_req_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |-> (req_cnt < cur_len))
    else $error("more reads than the byte count");

  assert_send_queued_R4: assert property (@(posedge clk) disable iff (!rst_n)
    tx_active |-> cur_pending)
    else $error("frame offered for an unqueued slot");
endmodule

// File: rtl/tx_desc_engine.sv
module tx_desc_engine
  import txd_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 4,
  parameter int unsigned FIFO_DEPTH = 64,
  localparam int unsigned SW  = $clog2(NUM_SLOTS),
  localparam int unsigned RAW = $clog2(2 * NUM_SLOTS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr_en,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_rd_en,
  output logic [31:0]    mem_addr,
  input  logic [7:0]     mem_rd_data,
  output logic           tx_active,
  output logic [7:0]     tx_data,
  output logic           tx_last,
  input  logic           mac_pull,
  input  logic           mac_done,
  input  logic [2:0]     mac_err,
  output logic           irq_tx_ok,
  output logic           irq_tx_err
);
  logic [SW-1:0]    cur_slot;
  logic             cur_pending;
  logic [AW-1:0]    cur_addr;
  logic [LEN_W-1:0] cur_len;
  logic [THR_W-1:0] cur_thr;
  logic             ev_fetch_done, ev_underrun, ev_complete, cmp_ok;
  logic [2:0]       cmp_mac_err;

  txd_desc_regs #(.NUM_SLOTS(NUM_SLOTS)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .reg_wr_en    (reg_wr_en),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .cur_slot     (cur_slot),
    .cur_pending  (cur_pending),
    .cur_addr     (cur_addr),
    .cur_len      (cur_len),
    .cur_thr      (cur_thr),
    .own_set      (ev_fetch_done),
    .cmp_valid    (ev_complete),
    .cmp_ok       (cmp_ok),
    .cmp_underrun (ev_underrun),
    .cmp_mac_err  (cmp_mac_err),
    .irq_ok       (irq_tx_ok),
    .irq_err      (irq_tx_err)
  );

  txd_xfer_ctrl #(.FIFO_DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .cur_pending   (cur_pending),
    .cur_addr      (cur_addr),
    .cur_len       (cur_len),
    .cur_thr       (cur_thr),
    .mem_rd_en     (mem_rd_en),
    .mem_addr      (mem_addr),
    .mem_rd_data   (mem_rd_data),
    .tx_active     (tx_active),
    .tx_data       (tx_data),
    .tx_last       (tx_last),
    .mac_pull      (mac_pull),
    .mac_done      (mac_done),
    .mac_err       (mac_err),
    .ev_fetch_done (ev_fetch_done),
    .ev_underrun   (ev_underrun),
    .ev_complete   (ev_complete),
    .cmp_ok        (cmp_ok),
    .cmp_mac_err   (cmp_mac_err)
  );

  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_complete && cmp_ok) |=> $stable(cur_slot))
    else $error("slot pointer moved without a good completion");

  assert_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> !tx_active)
    else $error("frame still offered after underrun");

  assert_txok_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_complete && cmp_ok) |=> irq_tx_ok)
    else $error("good completion without ok flag");

  assert_txerr_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_underrun |=> irq_tx_err)
    else $error("underrun without error flag");
endmodule

// File: tb/tx_desc_engine_bench.sv
`timescale 1ns/1ps
module tx_desc_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_rd_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_rd_data = '0;
  logic        tx_active, tx_last;
  logic [7:0]  tx_data;
  logic        mac_pull = 1'b0, mac_done = 1'b0;
  logic [2:0]  mac_err = '0;
  logic        irq_tx_ok, irq_tx_err;

  int checks = 0;
  int fails  = 0;
  int served = 0;

  always #2.5 clk = ~clk;

  tx_desc_engine u_tx_desc_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_rd_en(mem_rd_en),
    .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .tx_active(tx_active),
    .tx_data(tx_data), .tx_last(tx_last), .mac_pull(mac_pull),
    .mac_done(mac_done), .mac_err(mac_err), .irq_tx_ok(irq_tx_ok),
    .irq_tx_err(irq_tx_err)
  );

  function automatic logic [7:0] pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    if (mem_rd_en) begin
      mem_rd_data <= pat(mem_addr);
      served <= served + 1;
    end
  end

  // status word: count[12:0], host-owned 13, underrun 14, ok 15, threshold [21:16], mac errors [31:29]
  function automatic logic [31:0] exp_status(input int len, input int thr, input bit own,
                                             input bit unr, input bit ok, input logic [2:0] err);
    logic [31:0] v;
    v = 32'(len) | (32'(thr) << 16);
    if (own) v = v | 32'h2000;
    if (unr) v = v | 32'h4000;
    if (ok)  v = v | 32'h8000;
    v = v | (32'(err) << 29);
    return v;
  endfunction

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // act as the MAC: pull every other active cycle, check data and last flag
  task automatic run_frame(input logic [31:0] addr, input int len, input int base, input int lb);
    int idx = 0, cyc = 0, start_srv = -1, bad = 0, last_bad = 0;
    bit tog = 1'b0;
    logic [7:0] bad_act = '0, bad_exp = '0;
    while (idx < len && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (tx_active) begin
        if (start_srv < 0) start_srv = served - base;
        if (tog) begin
          mac_pull = 1'b1;
          if (tx_data !== pat(addr + 32'(idx))) begin
            if (bad == 0) begin bad_act = tx_data; bad_exp = pat(addr + 32'(idx)); end
            bad++;
          end
          if (tx_last !== (idx == len - 1)) last_bad++;
          idx++;
        end else mac_pull = 1'b0;
        tog = !tog;
      end else mac_pull = 1'b0;
    end
    @(negedge clk);
    mac_pull = 1'b0;
    check("R4 byte count delivered", idx == len, 32'(idx), 32'(len));
    check("R4 byte values in order", bad == 0, 32'(bad_act), 32'(bad_exp));
    check("R4 last flag on final byte only", last_bad == 0, 32'(last_bad), 0);
    check("R4 active drops after final byte", tx_active == 1'b0, 32'(tx_active), 0);
    if (lb >= 0)
      check("R5 start point", start_srv >= lb && start_srv <= lb + 3, 32'(start_srv), 32'(lb));
  endtask

  task automatic finish_frame(input int slot, input int len, input int thr, input logic [2:0] err);
    logic [31:0] d;
    reg_read(4'(slot), d);
    check("R6 owned bit set after fetch", d[13] == 1'b1 && d[15] == 1'b0, d, exp_status(len, thr, 1, 0, 0, 0));
    @(negedge clk);
    mac_done = 1'b1; mac_err = err;
    @(negedge clk);
    mac_done = 1'b0; mac_err = '0;
    reg_read(4'(slot), d);
    check("R7 status after done", d == exp_status(len, thr, 1, 0, err == 0, err), d,
          exp_status(len, thr, 1, 0, err == 0, err));
    reg_read(4'd8, d);
    check("R7 interrupt word", d == ((err == 0) ? 32'h4 : 32'h8), d, (err == 0) ? 32'h4 : 32'h8);
    check("R10 interrupt pins", {irq_tx_err, irq_tx_ok} == ((err == 0) ? 2'b01 : 2'b10),
          32'({irq_tx_err, irq_tx_ok}), (err == 0) ? 32'h1 : 32'h2);
    reg_write(4'd8, 32'hC);
  endtask

  typedef struct packed {
    logic [1:0]  slot;
    logic [31:0] addr;
    logic [12:0] len;
    logic [5:0]  thr;
    logic [2:0]  err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{2'd0, 32'h0000_1000, 13'd60,  6'd1,  3'b000},  // threshold 32 bytes
    '{2'd1, 32'h0000_2003, 13'd20,  6'd8,  3'b000},  // whole frame shorter than threshold
    '{2'd2, 32'h0000_30F0, 13'd100, 6'd63, 3'b000},  // threshold beyond FIFO: start when full
    '{2'd3, 32'h0000_7777, 13'd45,  6'd1,  3'b100},  // carrier lost: pointer holds
    '{2'd3, 32'h0000_8000, 13'd45,  6'd1,  3'b000},  // retry same slot
    '{2'd0, 32'h0000_0FFE, 13'd33,  6'd2,  3'b000}   // wraps across a 4K boundary
  };

  function automatic int start_lb(input int len, input int thr);
    int lb = thr * 32;
    if (len < lb) lb = len;
    if (64 < lb) lb = 64;
    return lb;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      reg_read(4'(s), d);
      check("R1 status reset", d == 32'h2000, d, 32'h2000);
      reg_read(4'(4 + s), d);
      check("R1 address reset", d == 0, d, 0);
    end
    reg_read(4'd8, d);
    check("R1 interrupt reset", d == 0, d, 0);
    check("R1 outputs idle", {tx_active, mem_rd_en} == 2'b00, 32'({tx_active, mem_rd_en}), 0);

    // vector table
    foreach (VECS[i]) begin
      reg_write(4'(4 + VECS[i].slot), VECS[i].addr);
      reg_read(4'(4 + VECS[i].slot), d);
      check("R2 address readback", d == VECS[i].addr, d, VECS[i].addr);
      base = served;
      reg_write(4'(VECS[i].slot), 32'hE000_C000 | (32'(VECS[i].thr) << 16) | 32'(VECS[i].len));
      reg_read(4'(VECS[i].slot), d);
      check("R3 status write clears flags", d == exp_status(VECS[i].len, VECS[i].thr, 0, 0, 0, 0), d,
            exp_status(VECS[i].len, VECS[i].thr, 0, 0, 0, 0));
      run_frame(VECS[i].addr, int'(VECS[i].len), base, start_lb(VECS[i].len, VECS[i].thr));
      finish_frame(VECS[i].slot, int'(VECS[i].len), int'(VECS[i].thr), VECS[i].err);
    end

    // R8: pointer is at slot 1; queue slot 2 first, it must wait
    reg_write(4'd6, 32'h0000_5000);
    base = served;
    reg_write(4'd2, (32'd1 << 16) | 32'd10);
    repeat (20) @(negedge clk);
    check("R8 out-of-turn slot waits", served == base && tx_active == 1'b0, 32'(served - base), 0);
    reg_write(4'd5, 32'h0000_4000);
    base = served;
    reg_write(4'd1, (32'd1 << 16) | 32'd12);
    run_frame(32'h0000_4000, 12, base, 12);
    finish_frame(1, 12, 1, 3'b000);
    run_frame(32'h0000_5000, 10, 0, -1);
    finish_frame(2, 10, 1, 3'b000);

    // R9: underrun on slot 3 with zero threshold, pull on first active cycle
    reg_write(4'd7, 32'h0000_9000);
    reg_write(4'd3, 32'd50);
    begin
      int w = 0;
      while (!tx_active && w < 100) begin @(negedge clk); w++; end
    end
    mac_pull = 1'b1;
    @(negedge clk);
    mac_pull = 1'b0;
    check("R9 frame abandoned", tx_active == 1'b0, 32'(tx_active), 0);
    reg_read(4'd3, d);
    check("R9 underrun status", d == exp_status(50, 0, 1, 1, 0, 0), d, exp_status(50, 0, 1, 1, 0, 0));
    reg_read(4'd8, d);
    check("R9 error interrupt", d == 32'h8, d, 32'h8);

    // R10: writing 0 keeps the flag
    reg_write(4'd8, 32'h0);
    reg_read(4'd8, d);
    check("R10 zero write keeps flag", d == 32'h8, d, 32'h8);

    // R9 pointer stayed on slot 3: retry must run
    base = served;
    reg_write(4'd3, (32'd1 << 16) | 32'd10);
    run_frame(32'h0000_9000, 10, base, 10);
    @(negedge clk);
    mac_done = 1'b1;
    @(negedge clk);
    mac_done = 1'b0;
    reg_read(4'd8, d);
    check("R10 both flags set", d == 32'hC, d, 32'hC);
    reg_write(4'd8, 32'h8);
    reg_read(4'd8, d);
    check("R10 one-write clears only bit3", d == 32'h4 && irq_tx_ok && !irq_tx_err, d, 32'h4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule